// File: doc/BRIEF.md
# Registered-Input Single-Port Static Memory Core

This block is a single-port synchronous static memory with a shared data path. Address, chip select, write enable and write data are captured on the rising clock edge. A write stores the captured word into an inferred register array at the following edge. A read returns a word from the array. In a chip the shared bus is represented by three signals: an input word `dq_i`, an output word `dq_o` and a drive enable `dq_oe_o`. When `dq_oe_o` is low, the pad is high impedance.

Parameter `PIPELINED` selects the read latency. With 0 (flowthrough), the array output goes straight to the pins after the input registers. With 1, an output data register adds one cycle. Parameter `DOUBLE_DESELECT` keeps the driver on for one extra cycle after a deselect that follows a read. This option needs the output register, so it is rejected at elaboration when `PIPELINED` is 0. The output enable is not registered and gates the driver without a clock.

The host must leave a dead cycle before turning the bus from a read to a write, and must drop the output enable where the driver would still be active.

Top module: `sync_sram_core`

## Requirements
- R1: After reset, `dq_oe_o` is low and stays low until a read reaches the output stage.
- R2: A read issued at the edge right after a write to the same address returns the newly written word.
- R3: Flowthrough (`PIPELINED`=0): a read captured at edge E0 places the word on `dq_o` with `dq_oe_o` high from E0 until E1.
- R4: Pipelined (`PIPELINED`=1): a read captured at edge E0 places the word on `dq_o` with `dq_oe_o` high from E1 until E2.
- R5: Reads issued on consecutive edges produce one word per cycle, in issue order, with no gap.
- R6: With single-cycle deselect, the driver turns off in the first output slot that belongs to a deselected cycle.
- R7: With double-cycle deselect, a read followed by a deselect keeps `dq_oe_o` high for one more cycle, repeating the last word, and then turns it off.
- R8: With double-cycle deselect, a read followed directly by a write gets no extra drive cycle.
- R9: `oe_i` low forces `dq_oe_o` low without a clock edge. Reads issued while `oe_i` is low still move through the pipeline, and their words appear as soon as `oe_i` rises.
- R10: Output slots that belong to writes or idle cycles never raise `dq_oe_o`.
- R11: A write enable with chip select low leaves the array unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all captures on rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select, active high |
| we_i | input | 1 | 1 = write, 0 = read, when selected |
| oe_i | input | 1 | Output enable, active high, not registered |
| addr_i | input | ADDR_W | Word address |
| dq_i | input | DATA_W | Write data from the bus |
| dq_o | output | DATA_W | Read data toward the bus |
| dq_oe_o | output | 1 | Bus driver enable |

## Verification
Three instances share one stimulus: flowthrough, pipelined with single deselect, and pipelined with double deselect. Each instance is checked against its own latency.

A lone read framed by idle cycles shows where each variant turns its driver on and off. A stream of reads to scattered addresses tells true one-word-per-cycle streaming apart from repeated or shifted words. A write followed at once by a read of the same word catches stale array data. A read followed directly by a write separates the deselect extension from the plain end of a read. Reads with `oe_i` low, and a selected-off write, show that gating and ignored commands touch nothing else.

// File: rtl/sync_sram_pkg.sv
`timescale 1ns/1ps
package sync_sram_pkg;
  typedef struct packed {
    logic sel;
    logic wr;
  } sram_cmd_t;

  function automatic int unsigned rd_latency(input bit pipelined);
    return pipelined ? 2 : 1;
  endfunction
endpackage

// File: rtl/sram_in_stage.sv
`timescale 1ns/1ps
module sram_in_stage
  import sync_sram_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output sram_cmd_t         cmd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_o   <= '0;
      addr_o  <= '0;
      wdata_o <= '0;
    end else begin
      cmd_o.sel <= cs_i;
      cmd_o.wr  <= cs_i & we_i;
      if (cs_i) begin
        addr_o  <= addr_i;
        wdata_o <= wdata_i;
      end
    end
  end
endmodule

// File: rtl/sram_array.sv
`timescale 1ns/1ps
module sram_array #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  // asynchronous read off the registered address
  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/sram_out_stage.sv
`timescale 1ns/1ps
module sram_out_stage
  import sync_sram_pkg::*;
#(
  parameter int unsigned DATA_W          = 16,
  parameter bit          PIPELINED       = 1'b1,
  parameter bit          DOUBLE_DESELECT = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  sram_cmd_t         cmd_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              oe_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o
);
  logic rd_slot;
  logic drive;

  assign rd_slot = cmd_i.sel & ~cmd_i.wr;

  if (PIPELINED) begin : g_pipe
    logic [DATA_W-1:0] out_q;
    logic              vld_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        out_q <= '0;
        vld_q <= 1'b0;
      end else begin
        vld_q <= rd_slot;
        if (rd_slot) out_q <= rdata_i;
      end
    end

    if (DOUBLE_DESELECT) begin : g_dcd
      logic hold_q;
      // extend only when the slot after a read was a deselect
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) hold_q <= 1'b0;
        else         hold_q <= vld_q & ~cmd_i.sel;
      end
      assign drive = vld_q | hold_q;
    end else begin : g_scd
      assign drive = vld_q;
    end

    assign dq_o = out_q;
  end else begin : g_flow
    assign dq_o  = rdata_i;
    assign drive = rd_slot;
  end

  assign dq_oe_o = oe_i & drive;
endmodule

// File: rtl/sync_sram_core.sv
`timescale 1ns/1ps
module sync_sram_core
  import sync_sram_pkg::*;
#(
  parameter int unsigned ADDR_W          = 6,
  parameter int unsigned DATA_W          = 16,
  parameter bit          PIPELINED       = 1'b1,
  parameter bit          DOUBLE_DESELECT = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              we_i,
  input  logic              oe_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o
);
  if (DOUBLE_DESELECT && !PIPELINED) begin : g_bad_cfg
    $error("double deselect requires the pipelined output register");
  end

  sram_cmd_t         cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata;

  sram_in_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_in (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cs_i    (cs_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (dq_i),
    .cmd_o   (cmd_q),
    .addr_o  (addr_q),
    .wdata_o (wdata_q)
  );

  sram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk_i   (clk_i),
    .we_i    (cmd_q.wr),
    .addr_i  (addr_q),
    .wdata_i (wdata_q),
    .rdata_o (rdata)
  );

  sram_out_stage #(
    .DATA_W          (DATA_W),
    .PIPELINED       (PIPELINED),
    .DOUBLE_DESELECT (DOUBLE_DESELECT)
  ) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cmd_i   (cmd_q),
    .rdata_i (rdata),
    .oe_i    (oe_i),
    .dq_o    (dq_o),
    .dq_oe_o (dq_oe_o)
  );
endmodule

// File: rtl/sync_sram_core_chk.sv
`timescale 1ns/1ps
module sync_sram_core_chk #(
  parameter int unsigned DATA_W          = 16,
  parameter bit          PIPELINED       = 1'b1,
  parameter bit          DOUBLE_DESELECT = 1'b0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_i,
  input logic              we_i,
  input logic              oe_i,
  input logic [DATA_W-1:0] dq_o,
  input logic              dq_oe_o
);
  localparam int unsigned LAT = sync_sram_pkg::rd_latency(PIPELINED);

  logic [1:0] cyc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cyc_q <= '0;
    else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
  end

  a_r9_oe_gates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_i |-> !dq_oe_o);

  // R3 / R4
  a_r4_read_drives: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= LAT) && $past(cs_i && !we_i, LAT) && oe_i |-> dq_oe_o);

  a_r10_write_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= LAT) && $past(cs_i && we_i, LAT) |-> !dq_oe_o);

  if (!DOUBLE_DESELECT) begin : g_scd
    a_r6_scd_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cyc_q >= LAT) && $past(!cs_i, LAT) |-> !dq_oe_o);
  end else begin : g_dcd
    a_r7_dcd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cyc_q == 2'd3) && $past(cs_i && !we_i, 3) && $past(!cs_i, 2) && oe_i
      |-> dq_oe_o && $stable(dq_o));
  end
endmodule

bind sync_sram_core sync_sram_core_chk #(
  .DATA_W          (DATA_W),
  .PIPELINED       (PIPELINED),
  .DOUBLE_DESELECT (DOUBLE_DESELECT)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cs_i    (cs_i),
  .we_i    (we_i),
  .oe_i    (oe_i),
  .dq_o    (dq_o),
  .dq_oe_o (dq_oe_o)
);

// File: tb/sync_sram_core_bench.sv
`timescale 1ns/1ps
module sync_sram_core_bench;
  localparam int unsigned AW = 6;
  localparam int unsigned DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cs = 1'b0, we = 1'b0, oe = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] p_dq, f_dq, d_dq;
  logic          p_oe, f_oe, d_oe;
  logic [DW-1:0] model_q [1<<AW];
  int            n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  sync_sram_core #(.ADDR_W(AW), .DATA_W(DW), .PIPELINED(1'b1), .DOUBLE_DESELECT(1'b0))
  u_sync_sram_core (.clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .we_i(we), .oe_i(oe),
    .addr_i(addr), .dq_i(wdata), .dq_o(p_dq), .dq_oe_o(p_oe));

  sync_sram_core #(.ADDR_W(AW), .DATA_W(DW), .PIPELINED(1'b0), .DOUBLE_DESELECT(1'b0))
  u_ft (.clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .we_i(we), .oe_i(oe),
    .addr_i(addr), .dq_i(wdata), .dq_o(f_dq), .dq_oe_o(f_oe));

  sync_sram_core #(.ADDR_W(AW), .DATA_W(DW), .PIPELINED(1'b1), .DOUBLE_DESELECT(1'b1))
  u_dcd (.clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .we_i(we), .oe_i(oe),
    .addr_i(addr), .dq_i(wdata), .dq_o(d_dq), .dq_oe_o(d_oe));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive one command, return at the negedge after its capture edge
  task automatic issue(input logic c, input logic w, input logic [AW-1:0] a,
                       input logic [DW-1:0] d);
    cs = c; we = w; addr = a; wdata = d;
    if (c && w) model_q[a] = d;
    @(negedge clk);
  endtask

  task automatic nop();
    issue(1'b0, 1'b0, '0, '0);
  endtask

  task automatic t_reset();
    check("R1 pipe oe after reset", {31'd0, p_oe}, 0);
    check("R1 flow oe after reset", {31'd0, f_oe}, 0);
    check("R1 dcd oe after reset", {31'd0, d_oe}, 0);
  endtask

  task automatic t_fill();
    for (int i = 0; i < 8; i++) begin
      issue(1'b1, 1'b1, AW'(i), DW'(16'hA500 + i * 16'h0111));
      check("R10 flow quiet on write", {31'd0, f_oe}, 0);
      check("R10 pipe quiet on write", {31'd0, p_oe}, 0);
    end
    nop();
    check("R10 pipe quiet after write", {31'd0, p_oe}, 0);
    check("R10 dcd quiet after write", {31'd0, d_oe}, 0);
    nop();
  endtask

  task automatic t_single_read(input logic [AW-1:0] a);
    issue(1'b1, 1'b0, a, '0);
    check("R3 flow oe", {31'd0, f_oe}, 1);
    check("R3 flow data", {16'd0, f_dq}, {16'd0, model_q[a]});
    check("R4 pipe not yet", {31'd0, p_oe}, 0);
    nop();
    check("R6 flow off after deselect", {31'd0, f_oe}, 0);
    check("R4 pipe oe", {31'd0, p_oe}, 1);
    check("R4 pipe data", {16'd0, p_dq}, {16'd0, model_q[a]});
    check("R4 dcd data", {16'd0, d_dq}, {16'd0, model_q[a]});
    nop();
    check("R6 pipe off after deselect", {31'd0, p_oe}, 0);
    check("R7 dcd still on", {31'd0, d_oe}, 1);
    check("R7 dcd repeats word", {16'd0, d_dq}, {16'd0, model_q[a]});
    nop();
    check("R7 dcd off", {31'd0, d_oe}, 0);
  endtask

  task automatic t_stream();
    logic [AW-1:0] seq [4] = '{6'd2, 6'd6, 6'd1, 6'd7};
    for (int k = 0; k < 4; k++) begin
      issue(1'b1, 1'b0, seq[k], '0);
      check("R5 flow stream", {15'd0, f_oe, f_dq}, {15'd0, 1'b1, model_q[seq[k]]});
      if (k > 0)
        check("R5 pipe stream", {15'd0, p_oe, p_dq}, {15'd0, 1'b1, model_q[seq[k-1]]});
    end
    nop();
    check("R5 pipe last word", {15'd0, p_oe, p_dq}, {15'd0, 1'b1, model_q[seq[3]]});
    nop(); nop();
  endtask

  task automatic t_raw();
    issue(1'b1, 1'b1, 6'd5, 16'hBEEF);
    issue(1'b1, 1'b0, 6'd5, '0);
    check("R2 flow new word", {16'd0, f_dq}, 32'h0000BEEF);
    nop();
    check("R2 pipe new word", {16'd0, p_dq}, 32'h0000BEEF);
    nop(); nop();
  endtask

  task automatic t_read_write();
    issue(1'b1, 1'b0, 6'd3, '0);
    issue(1'b1, 1'b1, 6'd9, 16'h1234);
    check("R8 dcd read word", {15'd0, d_oe, d_dq}, {15'd0, 1'b1, model_q[3]});
    nop();
    check("R8 dcd no extension before write", {31'd0, d_oe}, 0);
    check("R8 pipe off", {31'd0, p_oe}, 0);
    nop();
  endtask

  task automatic t_oe();
    oe = 1'b0;
    issue(1'b1, 1'b0, 6'd4, '0);
    check("R9 flow gated", {31'd0, f_oe}, 0);
    oe = 1'b1; #1;
    check("R9 flow on without edge", {15'd0, f_oe, f_dq}, {15'd0, 1'b1, model_q[4]});
    nop();
    check("R9 pipe word advanced", {15'd0, p_oe, p_dq}, {15'd0, 1'b1, model_q[4]});
    oe = 1'b0; #1;
    check("R9 pipe gated", {31'd0, p_oe}, 0);
    check("R9 dcd gated", {31'd0, d_oe}, 0);
    oe = 1'b1;
    nop(); nop();
  endtask

  task automatic t_ignored_write();
    logic [DW-1:0] keep = model_q[6];
    cs = 1'b0; we = 1'b1; addr = 6'd6; wdata = 16'hDEAD;
    @(negedge clk);
    check("R10 flow quiet on deselect", {31'd0, f_oe}, 0);
    issue(1'b1, 1'b0, 6'd6, '0);
    check("R11 word unchanged", {16'd0, f_dq}, {16'd0, keep});
    nop(); nop(); nop();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill();
    t_single_read(6'd3);
    t_stream();
    t_raw();
    t_read_write();
    t_oe();
    t_ignored_write();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule